// File: doc/BRIEF.md
# Segmented DAC Switch-Control Encoder

This block is the digital front end of a segmented current-steering converter. Each input word is split into an upper field and a lower field. The upper field is expanded into a thermometer code of 2^MSB_W−1 unit-element enables. Those enables are then placed onto physical unit cells. In symmetric mode the placement starts at the centre cell and alternates outward. In sequential mode it runs in plain index order. The lower field drives the binary-weighted cell enables unchanged.

Every enable is held in its own output flip-flop, and all of these flip-flops switch on one common clock edge. A one-hot vector marks the physical unit cell that will turn on next, which is the first cell that is still off.

The input is captured in an input register together with its mode bit and a valid flag. The result leaves through the output register one clock later. While the valid flag is low, both registers hold their contents.

Top module: `segdac_switch_enc`

## Requirements
- R1: A synchronous active-high reset `rst` clears `unitEn`, `binEn`, `nextUnit` and `outValid` to zero.
- R2: A word presented with `inValid`=1 before rising edge k appears on all outputs after rising edge k+1, with `outValid`=1. After edge k alone, the outputs still show the previous result.
- R3: A word presented with `inValid`=0 has no effect on `unitEn`, `binEn` or `nextUnit`, which keep their last values. `outValid` goes to 0 with the same two-edge latency.
- R4: The number of set bits in `unitEn` equals k, the value of the upper field `inCode[MSB_W+LSB_W-1:LSB_W]`.
- R5: With `symMode`=0, unit cell p is on exactly when p < k.
- R6: With `symMode`=1, thermometer ordinal j goes to cell c for j=0, to cell c−(j+1)/2 for odd j, and to cell c+j/2 for even j>0, where c = 2^(MSB_W−1)−1. For the default width the order is 7,6,8,5,9,4,10,3,11,2,12,1,13,0,14. Cell p is on exactly when its ordinal is below k.
- R7: Within one mode, raising k only turns additional unit cells on. The set of cells that are on for k is contained in the set that is on for k+1.
- R8: `binEn` equals the lower field `inCode[LSB_W-1:0]`.
- R9: When k < 2^MSB_W−1, `nextUnit` is one-hot on the cell that holds ordinal k in the selected mode. That cell is off in `unitEn`. When k = 2^MSB_W−1, `nextUnit` is all zeros.
- R10: `symMode` is sampled together with `inCode` and follows the same latency. A mode change therefore takes effect with the word it accompanies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Marks `inCode` and `symMode` as a word to be loaded |
| inCode | input | MSB_W+LSB_W | Binary input word: upper field for the unit cells, lower field for the binary cells |
| symMode | input | 1 | 1 selects centre-out placement, 0 selects sequential placement |
| outValid | output | 1 | High while the outputs carry a word that was loaded with `inValid`=1 |
| unitEn | output | 2^MSB_W−1 | Registered enables of the physical unit cells |
| binEn | output | LSB_W | Registered enables of the binary-weighted cells |
| nextUnit | output | 2^MSB_W−1 | One-hot marker of the next unit cell to turn on; zero when all are on |

## Verification
The bench sweeps every input code upward in both modes. It compares the exact physical enable pattern with an independently built centre-out order. A placement error would show a cell flipped out of order or a broken subset chain, and a decoder off by one would give a set-bit count that differs from the upper field.

The extremes get their own checks. Code zero must produce no enables and a marker on the centre cell. Full scale must produce all enables and an empty marker, which catches a marker that wraps around or points at a cell that is already on. Latency and hold are probed by sampling after the first edge and by feeding invalid words. A pipeline that is one stage short, or an output register that loads regardless of the valid flag, then shows up as early or corrupted outputs.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadIn;   // capture the input word
    logic loadOut;  // launch decoded enables into the output flops
  } segStrobe_t;

  // ordinal of physical cell p in centre-out placement around centre c
  function automatic int symOrdinal(input int p, input int c);
    if (p == c) return 0;
    else if (p < c) return 2 * (c - p) - 1;
    else return 2 * (p - c);
  endfunction

endpackage

// File: rtl/segdac_ctrl.sv
module segdac_ctrl (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  output segdac_pkg::segStrobe_t strobe,
  output logic                   outValid
);
  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    strobe.loadIn  = inValid;
    strobe.loadOut = stage1Valid;
  end

  assign outValid = stage2Valid;

  // R2
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    $past(inValid, 2) |-> outValid);

  // R3
  invalid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid, 2) |-> !outValid);

endmodule

// File: rtl/segdac_datapath.sv
module segdac_datapath #(
  parameter int MSB_W = 4,
  parameter int LSB_W = 4,
  localparam int NU   = (1 << MSB_W) - 1,
  localparam int CTR  = (1 << (MSB_W - 1)) - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  segdac_pkg::segStrobe_t strobe,
  input  logic [MSB_W+LSB_W-1:0] inCode,
  input  logic                   symMode,
  output logic [NU-1:0]          unitEn,
  output logic [LSB_W-1:0]       binEn,
  output logic [NU-1:0]          nextUnit
);
  logic [MSB_W-1:0] msbQ;
  logic [LSB_W-1:0] lsbQ;
  logic             modeQ;

  // input register
  always_ff @(posedge clk) begin
    if (rst) begin
      msbQ  <= '0;
      lsbQ  <= '0;
      modeQ <= 1'b0;
    end else if (strobe.loadIn) begin
      msbQ  <= inCode[MSB_W+LSB_W-1:LSB_W];
      lsbQ  <= inCode[LSB_W-1:0];
      modeQ <= symMode;
    end
  end

  // thermometer by ordinal and one-hot of the first off ordinal
  logic [NU-1:0] thermOrd;
  logic [NU-1:0] nextOrd;
  for (genvar j = 0; j < NU; j++) begin : g_ord
    assign thermOrd[j] = int'(msbQ) > j;
    assign nextOrd[j]  = int'(msbQ) == j;
  end

  // ordinal-to-physical placement
  logic [NU-1:0] unitD;
  logic [NU-1:0] nextD;
  for (genvar p = 0; p < NU; p++) begin : g_place
    localparam int SO = segdac_pkg::symOrdinal(p, CTR);
    assign unitD[p] = modeQ ? thermOrd[SO] : thermOrd[p];
    assign nextD[p] = modeQ ? nextOrd[SO]  : nextOrd[p];
  end

  // common-edge output register, one flop per enable
  always_ff @(posedge clk) begin
    if (rst) begin
      unitEn   <= '0;
      binEn    <= '0;
      nextUnit <= '0;
    end else if (strobe.loadOut) begin
      unitEn   <= unitD;
      binEn    <= lsbQ;
      nextUnit <= nextD;
    end
  end

  // R4
  unit_count_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.loadOut) |-> $countones(unitEn) == int'($past(msbQ)));

  // R8
  bin_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.loadOut) |-> binEn == $past(lsbQ));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe.loadOut) |-> ($stable(unitEn) && $stable(binEn) && $stable(nextUnit)));

  // R9
  next_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(nextUnit));

  // R9
  next_off_chk: assert property (@(posedge clk) disable iff (rst)
    (nextUnit & unitEn) == '0);

  // R9
  next_full_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobe.loadOut) |-> ((nextUnit == '0) == (unitEn == {NU{1'b1}})));

endmodule

// File: rtl/segdac_switch_enc.sv
module segdac_switch_enc #(
  parameter int MSB_W = 4,
  parameter int LSB_W = 4,
  localparam int NU   = (1 << MSB_W) - 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic [MSB_W+LSB_W-1:0] inCode,
  input  logic                   symMode,
  output logic                   outValid,
  output logic [NU-1:0]          unitEn,
  output logic [LSB_W-1:0]       binEn,
  output logic [NU-1:0]          nextUnit
);
  segdac_pkg::segStrobe_t strobe;

  initial begin
    param_chk: assert (MSB_W >= 2 && MSB_W <= 6 && LSB_W >= 1);
  end

  segdac_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  segdac_datapath #(.MSB_W(MSB_W), .LSB_W(LSB_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .inCode   (inCode),
    .symMode  (symMode),
    .unitEn   (unitEn),
    .binEn    (binEn),
    .nextUnit (nextUnit)
  );

endmodule

// File: tb/segdac_switch_enc_test.sv
module segdac_switch_enc_test;
  localparam int MW = 4;
  localparam int LW = 4;
  localparam int NU = (1 << MW) - 1;
  localparam int CT = (1 << (MW - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [MW+LW-1:0] inCode = '0;
  logic          symMode = 1'b0;
  logic          outValid;
  logic [NU-1:0] unitEn;
  logic [LW-1:0] binEn;
  logic [NU-1:0] nextUnit;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  segdac_switch_enc #(.MSB_W(MW), .LSB_W(LW)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inCode(inCode), .symMode(symMode),
    .outValid(outValid), .unitEn(unitEn), .binEn(binEn), .nextUnit(nextUnit)
  );

  // physical cell for ordinal j: centre, then one left, one right, ...
  function automatic int cellOf(input int j, input bit sym);
    if (!sym) return j;
    if (j == 0) return CT;
    if (j % 2 == 1) return CT - (j + 1) / 2;
    return CT + j / 2;
  endfunction

  function automatic logic [NU-1:0] expUnit(input int k, input bit sym);
    logic [NU-1:0] v = '0;
    for (int j = 0; j < k; j++) v[cellOf(j, sym)] = 1'b1;
    return v;
  endfunction

  function automatic logic [NU-1:0] expNext(input int k, input bit sym);
    logic [NU-1:0] v = '0;
    if (k < NU) v[cellOf(k, sym)] = 1'b1;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one valid word and wait until its result is out; sample at negedge
  task automatic applyWord(input logic [MW+LW-1:0] code, input bit sym);
    @(negedge clk);
    inValid = 1'b1; inCode = code; symMode = sym;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkWord(input logic [MW+LW-1:0] code, input bit sym);
    int k;
    k = int'(code[MW+LW-1:LW]);
    check(outValid == 1'b1, "R2 valid", 32'(outValid), 32'd1);
    check($countones(unitEn) == k, "R4 count", 32'($countones(unitEn)), 32'(k));
    if (sym) check(unitEn == expUnit(k, 1'b1), "R6 sym map", 32'(unitEn), 32'(expUnit(k, 1'b1)));
    else     check(unitEn == expUnit(k, 1'b0), "R5 seq map", 32'(unitEn), 32'(expUnit(k, 1'b0)));
    check(binEn == code[LW-1:0], "R8 bin", 32'(binEn), 32'(code[LW-1:0]));
    check(nextUnit == expNext(k, sym), "R9 next", 32'(nextUnit), 32'(expNext(k, sym)));
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NU-1:0] prevU;
    logic [NU-1:0] holdU;
    logic [NU-1:0] holdN;
    logic [LW-1:0] holdB;
    void'($urandom(32'd1234));

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(unitEn == '0 && binEn == '0 && nextUnit == '0 && outValid == 1'b0,
          "R1 reset", {unitEn, binEn, 13'(nextUnit)}, 32'd0);
    rst = 1'b0;

    // full sweep in both modes: exact map, count, nesting (R7)
    for (int m = 0; m < 2; m++) begin
      prevU = '0;
      for (int c = 0; c < (1 << (MW + LW)); c++) begin
        applyWord((MW+LW)'(c), m[0]);
        checkWord((MW+LW)'(c), m[0]);
        check((prevU & ~unitEn) == '0, "R7 nested", 32'(unitEn), 32'(prevU));
        prevU = unitEn;
      end
    end

    // directed extremes
    applyWord('0, 1'b1);
    check(unitEn == '0 && nextUnit == NU'(1 << CT), "R9 zero code marks centre", 32'(nextUnit), 32'(1 << CT));
    applyWord({MW+LW{1'b1}}, 1'b1);
    check(unitEn == {NU{1'b1}} && nextUnit == '0, "R9 full scale empty marker", 32'(nextUnit), 32'd0);

    // R2 latency: after the first edge outputs still show the old word
    applyWord(8'h30, 1'b0);
    @(negedge clk);
    inValid = 1'b1; inCode = 8'hA5; symMode = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(unitEn == expUnit(3, 1'b0) && binEn == 4'h0, "R2 not yet", 32'(unitEn), 32'(expUnit(3, 1'b0)));
    @(posedge clk);
    @(negedge clk);
    check(unitEn == expUnit(10, 1'b0) && binEn == 4'h5, "R2 arrived", 32'(unitEn), 32'(expUnit(10, 1'b0)));

    // R10: mode change rides with its word
    applyWord(8'h50, 1'b1);
    check(unitEn == expUnit(5, 1'b1), "R10 mode to sym", 32'(unitEn), 32'(expUnit(5, 1'b1)));
    applyWord(8'h50, 1'b0);
    check(unitEn == expUnit(5, 1'b0), "R10 mode to seq", 32'(unitEn), 32'(expUnit(5, 1'b0)));

    // R3: invalid words are ignored
    applyWord(8'h6C, 1'b1);
    holdU = unitEn; holdB = binEn; holdN = nextUnit;
    @(negedge clk);
    inValid = 1'b0; inCode = 8'hF3; symMode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R3 valid low", 32'(outValid), 32'd0);
    check(unitEn == holdU && binEn == holdB && nextUnit == holdN, "R3 hold",
          32'(unitEn), 32'(holdU));

    // constrained random words
    for (int i = 0; i < 400; i++) begin
      logic [MW+LW-1:0] rc;
      bit rm;
      rc = (MW+LW)'($urandom);
      rm = 1'($urandom);
      applyWord(rc, rm);
      checkWord(rc, rm);
    end

    // R1 again mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(unitEn == '0 && binEn == '0 && nextUnit == '0 && outValid == 1'b0,
          "R1 reset mid-run", 32'(unitEn), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule